// File: doc/BRIEF.md
# Prescaled Auto-Reload Interval Timer

This block is a general-purpose interval timer built around one count register. Each qualified tick moves the count one step up or one step down. A tick comes either from every system clock cycle or from a synchronized rising edge on an external event line, and then passes through a programmable divider. When the count steps past its terminal value, the timer takes a programmable start value instead of restarting at zero, and it raises a sticky interrupt flag. Software acknowledges the flag by writing a one.

The timer has two modes. In free-running mode it keeps counting and reloading for as long as it is enabled. In single-shot mode it stops after the first terminal event and holds the reloaded value. It counts again only when it is disabled and re-enabled, or when it is cleared. With the event source selected, the same datapath serves as an event counter, for example for pulses from a sensor. The live count is always visible on an output port.

Top module: `interval_timer`

## Requirements
- R1: After reset the count is zero and the interrupt flag is low. The reload value and the prescale value are both zero.
- R2: With the system-clock source (src_sel = 0), enable high, up direction (count_down = 0) and a prescale value of 0 or 1, the count rises by exactly one on every clock edge.
- R3: Counting up, a tick taken at the all-ones count loads the reload value into the count and sets the interrupt flag in the same edge.
- R4: Counting down (count_down = 1), the count falls by one per tick. A tick taken at zero loads the reload value into the count and sets the interrupt flag.
- R5: A prescale value P of 2 or more makes the count advance once per P source ticks. The divider restarts from zero whenever enable is low, so a partial division is lost when the timer is paused.
- R6: The interrupt flag stays set until a cycle in which irq_ack is 1 and no new terminal event occurs. A terminal event in the same cycle as the acknowledge leaves the flag set.
- R7: In single-shot mode (single_shot = 1) the count stops after the first terminal event and holds the reloaded value. Counting resumes after enable has been low for at least one cycle, or after a clear.
- R8: While enable is low the count holds its value.
- R9: A clear forces the count to zero on the next edge. The clear takes priority over a tick in the same cycle.
- R10: With the event source selected (src_sel = 1), each rising edge of evt_in advances the prescaler input exactly once, however long the line stays high. This holds after a synchronizer of at least two flops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Gates counting; low also restarts the prescaler and releases a single-shot stop |
| clear | input | 1 | Forces the count to zero |
| src_sel | input | 1 | 0: every clock cycle is a source tick; 1: synchronized evt_in rising edges |
| evt_in | input | 1 | Asynchronous external event line |
| count_down | input | 1 | 0: count up, terminal at all-ones; 1: count down, terminal at zero |
| single_shot | input | 1 | 1: stop after the first terminal event |
| reload_we | input | 1 | Write strobe for the reload value |
| reload_wdata | input | CNT_W | New reload value |
| psc_we | input | 1 | Write strobe for the prescale value |
| psc_wdata | input | PSC_W | New prescale value (0 and 1 both divide by one) |
| irq_ack | input | 1 | Write-one acknowledge of the interrupt flag |
| count_o | output | CNT_W | Live count value |
| irq_o | output | 1 | Sticky terminal-event interrupt flag |

## Verification
The bench drives the counter through a set of runs that mix up and down direction, prescale values of 0, 1, 3, 4 and 7, reload values near both ends of the range, and both modes. Comparing each final count with an independent step model tells apart an off-by-one in the divider, reload versus wrap-to-zero at the terminal value, and a single-shot stop against a continued count. The directed cases cover the following. An acknowledge held through a stream of back-to-back terminal events separates set priority from clear priority. A pause in the middle of a division shows the divider restart. Long high pulses on the event line show one count per edge and not one per high cycle.

// File: rtl/itmr_pkg.sv
package itmr_pkg;
   typedef enum logic {
      SRC_SYSCLK = 1'b0,
      SRC_EVENT  = 1'b1
   } itmr_src_e;

   typedef enum logic {
      DIR_UP   = 1'b0,
      DIR_DOWN = 1'b1
   } itmr_dir_e;
endpackage

// File: rtl/itmr_evt_sync.sv
module itmr_evt_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic rise_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("itmr_evt_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] sync_q;
   logic              last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         last_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[STAGES-2:0], async_i};
         last_q <= sync_q[STAGES-1];
      end
   end

   assign rise_o = sync_q[STAGES-1] & ~last_q;

   // R10: an edge yields one pulse, never two back to back
   p_single_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> !rise_o);
endmodule

// File: rtl/itmr_prescaler.sv
module itmr_prescaler #(
   parameter int PSC_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic             clr_i,
   input  logic             src_tick_i,
   input  logic [PSC_W-1:0] div_i,
   output logic             tick_o
);
   generate
      if (PSC_W < 1 || PSC_W > 32) begin : g_bad_psc_w
         $error("itmr_prescaler: PSC_W out of range");
      end
   endgenerate

   logic [PSC_W-1:0] div_cnt_q;
   logic [PSC_W-1:0] last_idx;

   assign last_idx = (div_i == '0) ? '0 : div_i - 1'b1;
   assign tick_o   = run_i && src_tick_i && (div_cnt_q == last_idx);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_cnt_q <= '0;
      end else if (clr_i || !run_i) begin
         div_cnt_q <= '0;
      end else if (src_tick_i) begin
         if (div_cnt_q == last_idx) div_cnt_q <= '0;
         else                       div_cnt_q <= div_cnt_q + 1'b1;
      end
   end

   // R5: an output tick is only ever issued on a source tick
   p_tick_from_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o |-> src_tick_i);
   // R5: a paused divider starts again from its first step
   p_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !run_i |=> (div_cnt_q == '0));
endmodule

// File: rtl/itmr_count_core.sv
module itmr_count_core #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  logic             clr_i,
   input  logic             tick_i,
   input  logic             dn_i,
   input  logic             one_shot_i,
   input  logic [CNT_W-1:0] reload_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             ovf_o,
   output logic             halt_o
);
   import itmr_pkg::*;

   localparam logic [CNT_W-1:0] TOP_VAL = '1;

   logic [CNT_W-1:0] cnt_q;
   logic             halt_q;
   logic             at_term;
   logic             step;
   itmr_dir_e        dir;

   assign dir     = itmr_dir_e'(dn_i);
   assign at_term = (dir == DIR_DOWN) ? (cnt_q == '0) : (cnt_q == TOP_VAL);
   assign step    = tick_i && en_i && !halt_q && !clr_i;
   assign ovf_o   = step && at_term;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         halt_q <= 1'b0;
      end else if (clr_i) begin
         cnt_q  <= '0;
         halt_q <= 1'b0;
      end else begin
         if (!en_i) halt_q <= 1'b0;
         if (step) begin
            if (at_term) begin
               cnt_q <= reload_i;
               if (one_shot_i) halt_q <= 1'b1;
            end else if (dir == DIR_DOWN) begin
               cnt_q <= cnt_q - 1'b1;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

   assign cnt_o  = cnt_q;
   assign halt_o = halt_q;

   p_up_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && en_i && !halt_q && !clr_i && !dn_i && cnt_q != TOP_VAL)
      |=> (cnt_q == $past(cnt_q) + 1'b1));
   p_up_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && en_i && !halt_q && !clr_i && !dn_i && cnt_q == TOP_VAL)
      |=> (cnt_q == $past(reload_i)));
   p_dn_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && en_i && !halt_q && !clr_i && dn_i && cnt_q == '0)
      |=> (cnt_q == $past(reload_i)));
   p_shot_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (halt_q && en_i && !clr_i) |=> $stable(cnt_q));
   p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_i && !clr_i) |=> $stable(cnt_q));
   p_clear_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/interval_timer.sv
module interval_timer #(
   parameter int CNT_W       = 16,
   parameter int PSC_W       = 16,
   parameter bit EVT_SRC_EN  = 1'b1,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             clear,
   input  logic             src_sel,
   input  logic             evt_in,
   input  logic             count_down,
   input  logic             single_shot,
   input  logic             reload_we,
   input  logic [CNT_W-1:0] reload_wdata,
   input  logic             psc_we,
   input  logic [PSC_W-1:0] psc_wdata,
   input  logic             irq_ack,
   output logic [CNT_W-1:0] count_o,
   output logic             irq_o
);
   import itmr_pkg::*;

   generate
      if (CNT_W < 2 || CNT_W > 64) begin : g_bad_cnt_w
         $error("interval_timer: CNT_W out of range");
      end
   endgenerate

   logic [CNT_W-1:0] reload_q;
   logic [PSC_W-1:0] psc_q;
   logic             irq_q;
   logic             evt_rise;
   logic             src_tick;
   logic             div_tick;
   logic             ovf;
   logic             halted;
   itmr_src_e        src;

   assign src = itmr_src_e'(src_sel);

   generate
      if (EVT_SRC_EN) begin : g_evt
         itmr_evt_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .async_i(evt_in),
            .rise_o (evt_rise)
         );
      end else begin : g_no_evt
         assign evt_rise = 1'b0;
      end
   endgenerate

   assign src_tick = (src == SRC_EVENT) ? evt_rise : 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reload_q <= '0;
         psc_q    <= '0;
      end else begin
         if (reload_we) reload_q <= reload_wdata;
         if (psc_we)    psc_q    <= psc_wdata;
      end
   end

   itmr_prescaler #(.PSC_W(PSC_W)) u_psc (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_i     (enable && !halted),
      .clr_i     (clear),
      .src_tick_i(src_tick),
      .div_i     (psc_q),
      .tick_o    (div_tick)
   );

   itmr_count_core #(.CNT_W(CNT_W)) u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .en_i      (enable),
      .clr_i     (clear),
      .tick_i    (div_tick),
      .dn_i      (count_down),
      .one_shot_i(single_shot),
      .reload_i  (reload_q),
      .cnt_o     (count_o),
      .ovf_o     (ovf),
      .halt_o    (halted)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       irq_q <= 1'b0;
      else if (ovf)     irq_q <= 1'b1;
      else if (irq_ack) irq_q <= 1'b0;
   end

   assign irq_o = irq_q;

   p_irq_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> irq_o);
   p_irq_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && !irq_ack) |=> irq_o);
   p_irq_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack && !ovf) |=> !irq_o);
endmodule

// File: tb/interval_timer_tb_top.sv
module interval_timer_tb_top;
   localparam int CW = 8;
   localparam int PW = 16;
   localparam int NVEC = 10;

   typedef struct packed {
      logic        dn;
      logic        shot;
      logic [7:0]  psc;
      logic [7:0]  rel;
      logic [15:0] edges;
   } vec_t;

   localparam vec_t VECS [NVEC] = '{
      '{1'b0, 1'b0, 8'd0, 8'h00, 16'd10},
      '{1'b0, 1'b0, 8'd1, 8'h00, 16'd20},
      '{1'b0, 1'b0, 8'd4, 8'h00, 16'd41},
      '{1'b0, 1'b0, 8'd0, 8'hF0, 16'd300},
      '{1'b1, 1'b0, 8'd0, 8'h20, 16'd5},
      '{1'b1, 1'b0, 8'd3, 8'h10, 16'd30},
      '{1'b0, 1'b1, 8'd0, 8'h80, 16'd260},
      '{1'b1, 1'b1, 8'd0, 8'h05, 16'd20},
      '{1'b0, 1'b0, 8'd7, 8'h00, 16'd100},
      '{1'b1, 1'b0, 8'd0, 8'h03, 16'd9}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          enable = 1'b0, clear = 1'b0, src_sel = 1'b0, evt_in = 1'b0;
   logic          count_down = 1'b0, single_shot = 1'b0;
   logic          reload_we = 1'b0, psc_we = 1'b0, irq_ack = 1'b0;
   logic [CW-1:0] reload_wdata = '0;
   logic [PW-1:0] psc_wdata = '0;
   logic [CW-1:0] count_o;
   logic          irq_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   interval_timer #(.CNT_W(CW), .PSC_W(PW)) dut_i (
      .clk(clk), .rst_n(rst_n), .enable(enable), .clear(clear),
      .src_sel(src_sel), .evt_in(evt_in), .count_down(count_down),
      .single_shot(single_shot), .reload_we(reload_we),
      .reload_wdata(reload_wdata), .psc_we(psc_we), .psc_wdata(psc_wdata),
      .irq_ack(irq_ack), .count_o(count_o), .irq_o(irq_o)
   );

   task automatic check(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // step model from the requirements: returns {irq, count}
   function automatic int model(bit dn, bit shot, int rel, int ticks);
      int c = 0;
      int f = 0;
      for (int i = 0; i < ticks; i++) begin
         if (dn) begin
            if (c == 0) begin c = rel; f = 1; if (shot) break; end
            else c = c - 1;
         end else begin
            if (c == 255) begin c = rel; f = 1; if (shot) break; end
            else c = c + 1;
         end
      end
      return (f << 8) | c;
   endfunction

   // clear, acknowledge and program in one cycle, settings then held
   task automatic setup(bit dn, bit shot, int psc, int rel);
      @(negedge clk);
      clear = 1'b1; irq_ack = 1'b1;
      reload_we = 1'b1; reload_wdata = rel[CW-1:0];
      psc_we = 1'b1; psc_wdata = psc[PW-1:0];
      count_down = dn; single_shot = shot;
      @(negedge clk);
      clear = 1'b0; irq_ack = 1'b0; reload_we = 1'b0; psc_we = 1'b0;
   endtask

   task automatic run(int edges);
      enable = 1'b1;
      repeat (edges) @(negedge clk);
      enable = 1'b0;
   endtask

   initial begin
      repeat (10000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual 1 expected 0");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 count", count_o, 0);
      check("R1 irq", irq_o, 0);
      rst_n = 1'b1;
      @(negedge clk);
      enable = 1'b1;
      repeat (3) @(negedge clk);
      enable = 1'b0;
      check("R1 reload/prescale zero: 3 ticks", count_o, 3);

      // table walk (R2, R3, R4, R5, R7)
      for (int v = 0; v < NVEC; v++) begin
         int ps;
         int res;
         ps = (VECS[v].psc < 2) ? 1 : int'(VECS[v].psc);
         setup(VECS[v].dn, VECS[v].shot, VECS[v].psc, VECS[v].rel);
         run(VECS[v].edges);
         res = model(VECS[v].dn, VECS[v].shot, VECS[v].rel, VECS[v].edges / ps);
         check($sformatf("R2/R3/R4/R5/R7 vec%0d count", v), count_o, res & 255);
         check($sformatf("R3/R4 vec%0d irq", v), irq_o, res >> 8);
      end

      // R7: single-shot resumes after enable low
      setup(1'b0, 1'b1, 0, 8'h80);
      run(260);
      check("R7 stopped", count_o, 8'h80);
      @(negedge clk);
      run(5);
      check("R7 resumed", count_o, 8'h85);

      // R8: enable low holds count
      repeat (6) @(negedge clk);
      check("R8 hold", count_o, 8'h85);

      // R9: clear beats a tick
      setup(1'b0, 1'b0, 0, 0);
      enable = 1'b1;
      repeat (5) @(negedge clk);
      clear = 1'b1;
      @(negedge clk);
      clear = 1'b0; enable = 1'b0;
      check("R9 clear priority", count_o, 0);

      // R5: divider restarts on pause
      setup(1'b0, 1'b0, 4, 0);
      run(3);
      @(negedge clk);
      run(3);
      check("R5 restart", count_o, 0);
      run(4);
      check("R5 one tick", count_o, 1);

      // R6: ack during continuous terminal events keeps flag set
      setup(1'b0, 1'b0, 0, 8'hFF);
      run(255);
      check("R6 no irq yet", irq_o, 0);
      enable = 1'b1; irq_ack = 1'b1;
      repeat (4) @(negedge clk);
      enable = 1'b0; irq_ack = 1'b0;
      check("R6 set wins over ack", irq_o, 1);
      repeat (3) @(negedge clk);
      check("R6 sticky", irq_o, 1);
      irq_ack = 1'b1;
      @(negedge clk);
      irq_ack = 1'b0;
      check("R6 ack clears", irq_o, 0);

      // R10: event source, one count per rising edge
      setup(1'b0, 1'b0, 0, 0);
      src_sel = 1'b1;
      enable = 1'b1;
      for (int k = 0; k < 3; k++) begin
         evt_in = 1'b1; repeat (5) @(negedge clk);
         evt_in = 1'b0; repeat (3) @(negedge clk);
      end
      repeat (4) @(negedge clk);
      check("R10 three edges", count_o, 3);
      evt_in = 1'b1; repeat (12) @(negedge clk);
      check("R10 level high counts once", count_o, 4);
      evt_in = 1'b0; repeat (4) @(negedge clk);
      enable = 1'b0;

      // R10 with R5: event source through divide-by-2
      setup(1'b0, 1'b0, 2, 0);
      enable = 1'b1;
      for (int k = 0; k < 6; k++) begin
         evt_in = 1'b1; repeat (3) @(negedge clk);
         evt_in = 1'b0; repeat (3) @(negedge clk);
      end
      repeat (4) @(negedge clk);
      enable = 1'b0;
      check("R10 divided events", count_o, 3);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule